// File: doc/BRIEF.md
# Administrative-Unit Pointer Interpreter with Alarm Fill

This block follows the pointer for one high-order path channel in an aligned byte stream. Each frame, an upstream framer marks the two pointer bytes (first byte, then second byte) and the payload bytes with strobes. The block judges each received pointer word and runs a three-state tracker with the states normal, loss-of-pointer and path-alarm. It then reports the active payload offset, the two path alarms, and a flag for each positive or negative justification.

The byte stream passes through with one register of delay. When either alarm is active, or when the force input is high, every payload byte is replaced with 8'hFF. Overhead and pointer bytes are never altered. Downstream logic uses the reported offset to find the start of the payload and treats the all-ones fill as the downstream alarm signal.

Top module: `auPtrInterp`

## Requirements
- R1: After reset the tracker is in loss-of-pointer (lopAlarm=1, aisAlarm=0), ptrValue is 0 and both justification flags are 0.
- R2: The pointer word is {H1[1:0],H2} and is valid when it is 782 or less. The NDF nibble H1[7:4] counts as normal when it is 0110 or differs from it in one bit. Three consecutive frames with a normal NDF and the same valid value make that value active and end loss-of-pointer.
- R3: In the normal state, an enabled NDF (1001 or one bit from it) with a valid value makes that value active in the same frame.
- R4: In the normal state, a normal-NDF word whose odd bits (9,7,5,3,1) differ from the active value in at least 3 places, while its even bits differ in fewer than 3, is a positive justification. ptrValue becomes active+1, wrapping from 782 to 0, and incEvent is held high until the next pointer evaluation.
- R5: The mirror case, with at least 3 even bits (8,6,4,2,0) differing and fewer than 3 odd bits, is a negative justification. ptrValue becomes active-1, wrapping from 0 to 782, and decEvent is held high until the next evaluation.
- R6: A justification word that arrives in any of the 3 frames after a pointer change does not alter ptrValue and raises neither flag.
- R7: Eight consecutive frames whose word is invalid (NDF neither normal nor enabled, or value above 782) declare loss-of-pointer.
- R8: Eight consecutive enabled-NDF frames declare loss-of-pointer.
- R9: Three consecutive frames with H1=H2=8'hFF declare the path alarm (aisAlarm=1, lopAlarm=0). The path alarm is cleared by three consecutive frames carrying the same valid normal-NDF value, which then becomes active.
- R10: A payload byte leaves as 8'hFF one cycle later when lopAlarm, aisAlarm or forceAis is high. Otherwise it leaves unchanged, and non-payload bytes always pass unchanged.
- R11: Alarms, ptrValue and the flags change only in the cycle after a second-pointer-byte strobe, and the two alarms are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rstN | input | 1 | Active-low synchronous reset |
| dataIn | input | 8 | Incoming aligned byte |
| h1Strobe | input | 1 | Marks the first pointer byte |
| h2Strobe | input | 1 | Marks the second pointer byte |
| payloadEn | input | 1 | Marks a payload byte |
| forceAis | input | 1 | Forces all-ones payload fill |
| dataOut | output | 8 | Outgoing byte, one cycle behind dataIn |
| ptrValue | output | 10 | Active payload offset |
| lopAlarm | output | 1 | Loss-of-pointer alarm |
| aisAlarm | output | 1 | Path alarm-indication state |
| incEvent | output | 1 | Last evaluation was a positive justification |
| decEvent | output | 1 | Last evaluation was a negative justification |

## Verification
The properties assume that each frame shows the first-byte strobe exactly one cycle before the second-byte strobe. They also assume that the strobes never overlap one another and that payloadEn never falls on a pointer byte. Under these assumptions, the only registers that can move the tracker are the ones updated at the second-byte cycle. The bench drives every frame through a single task that emits the first byte, the second byte and then one payload byte on consecutive cycles, so the stimulus never leaves that envelope.

// File: rtl/auPtrPkg.sv
package auPtrPkg;
  localparam int PTR_W = 10;
  localparam logic [PTR_W-1:0] ODD_MASK  = 10'h2AA;
  localparam logic [PTR_W-1:0] EVEN_MASK = 10'h155;
  localparam int FLIP_MAJ = 3;

  typedef struct packed {
    logic             eval;
    logic             allOnes;
    logic             ndfEn;
    logic             ndfNorm;
    logic             inRange;
    logic [PTR_W-1:0] ptr;
  } frameClass_t;

  typedef struct packed {
    logic fillOnes;
  } ctrlStrobe_t;
endpackage

// File: rtl/auPtrDatapath.sv
module auPtrDatapath import auPtrPkg::*; #(
  parameter int PTR_MAX = 782
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [7:0]  dataIn,
  input  logic        h1Strobe,
  input  logic        h2Strobe,
  input  logic        payloadEn,
  input  ctrlStrobe_t strb,
  output frameClass_t cls,
  output logic [7:0]  dataOut
);
  logic [7:0] h1Reg;
  logic [3:0] ndf;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      h1Reg   <= '0;
      dataOut <= '0;
    end else begin
      if (h1Strobe) h1Reg <= dataIn;
      dataOut <= (payloadEn && strb.fillOnes) ? 8'hFF : dataIn;
    end
  end

  assign ndf = h1Reg[7:4];

  always_comb begin
    cls.eval    = h2Strobe;
    cls.ptr     = {h1Reg[1:0], dataIn};
    cls.allOnes = (h1Reg == 8'hFF) && (dataIn == 8'hFF);
    cls.ndfEn   = $countones(ndf ^ 4'b1001) <= 1;
    cls.ndfNorm = $countones(ndf ^ 4'b0110) <= 1;
    cls.inRange = cls.ptr <= PTR_W'(PTR_MAX);
  end
endmodule

// File: rtl/auPtrControl.sv
module auPtrControl import auPtrPkg::*; #(
  parameter int PTR_MAX  = 782,
  parameter int ACCEPT_N = 3,
  parameter int LOP_N    = 8,
  parameter int AIS_N    = 3,
  parameter int GUARD_N  = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  frameClass_t      cls,
  input  logic             forceAis,
  output ctrlStrobe_t      strb,
  output logic [PTR_W-1:0] ptrValue,
  output logic             lopAlarm,
  output logic             aisAlarm,
  output logic             incEvent,
  output logic             decEvent
);
  localparam int AW = $clog2(ACCEPT_N + 1);
  localparam int LW = $clog2(LOP_N + 1);
  localparam int SW = $clog2(AIS_N + 1);
  localparam int GW = $clog2(GUARD_N + 1);
  localparam logic [AW-1:0] ACC_LAST = AW'(ACCEPT_N - 1);
  localparam logic [LW-1:0] LOP_LAST = LW'(LOP_N - 1);
  localparam logic [SW-1:0] AIS_LAST = SW'(AIS_N - 1);
  localparam logic [GW-1:0] GUARD_OK = GW'(GUARD_N);
  localparam logic [PTR_W-1:0] TOP = PTR_W'(PTR_MAX);

  typedef enum logic [1:0] {ST_NORM, ST_LOP, ST_AIS} ptrState_e;

  ptrState_e st, stN;
  logic [PTR_W-1:0] act, actN, cand, candN;
  logic [AW-1:0] cCnt, cCntN;
  logic [LW-1:0] inv, invN, ndfC, ndfN;
  logic [SW-1:0] aisC, aisN;
  logic [GW-1:0] sc, scN;
  logic incN, decN, oddFlip, evenFlip;

  assign oddFlip  = $countones((cls.ptr ^ act) & ODD_MASK)  >= FLIP_MAJ;
  assign evenFlip = $countones((cls.ptr ^ act) & EVEN_MASK) >= FLIP_MAJ;

  always_comb begin
    stN = st; actN = act; candN = cand; cCntN = cCnt; invN = inv;
    ndfN = ndfC; aisN = aisC; scN = sc; incN = incEvent; decN = decEvent;
    if (cls.eval) begin
      scN  = (sc == GUARD_OK) ? sc : sc + 1'b1;
      incN = 1'b0;
      decN = 1'b0;
      aisN = '0;
      if (cls.allOnes) begin
        ndfN = '0; cCntN = '0;
        aisN = aisC + 1'b1;
        if (aisC == AIS_LAST) begin
          stN = ST_AIS; aisN = '0; invN = '0;
        end
      end else if (st == ST_NORM && cls.ndfEn && cls.inRange) begin
        actN = cls.ptr; scN = '0; invN = '0; cCntN = '0;
        ndfN = ndfC + 1'b1;
        if (ndfC == LOP_LAST) begin
          stN = ST_LOP; ndfN = '0;
        end
      end else if (st == ST_NORM && cls.ndfNorm && cls.ptr == act) begin
        invN = '0; ndfN = '0; cCntN = '0;
      end else if (st == ST_NORM && cls.ndfNorm && (oddFlip != evenFlip)) begin
        ndfN = '0;
        if (sc == GUARD_OK) begin
          scN = '0; invN = '0; cCntN = '0;
          if (oddFlip) begin
            actN = (act == TOP) ? '0 : act + 1'b1;
            incN = 1'b1;
          end else begin
            actN = (act == '0) ? TOP : act - 1'b1;
            decN = 1'b1;
          end
        end
      end else if (cls.ndfNorm && cls.inRange) begin
        ndfN  = '0;
        candN = cls.ptr;
        cCntN = (cls.ptr == cand && cCnt != '0) ? cCnt + 1'b1 : AW'(1);
        if (cls.ptr == cand && cCnt == ACC_LAST) begin
          actN = cls.ptr; stN = ST_NORM; scN = '0; invN = '0; cCntN = '0;
        end else if (st != ST_LOP) begin
          invN = inv + 1'b1;
          if (inv == LOP_LAST) begin
            stN = ST_LOP; invN = '0;
          end
        end
      end else begin
        ndfN = '0; cCntN = '0;
        if (st != ST_LOP) begin
          invN = inv + 1'b1;
          if (inv == LOP_LAST) begin
            stN = ST_LOP; invN = '0;
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st <= ST_LOP; act <= '0; cand <= '0; cCnt <= '0; inv <= '0;
      ndfC <= '0; aisC <= '0; sc <= '0; incEvent <= 1'b0; decEvent <= 1'b0;
    end else begin
      st <= stN; act <= actN; cand <= candN; cCnt <= cCntN; inv <= invN;
      ndfC <= ndfN; aisC <= aisN; sc <= scN; incEvent <= incN; decEvent <= decN;
    end
  end

  assign ptrValue      = act;
  assign lopAlarm      = (st == ST_LOP);
  assign aisAlarm      = (st == ST_AIS);
  assign strb.fillOnes = lopAlarm | aisAlarm | forceAis;
endmodule

// File: rtl/auPtrInterp.sv
module auPtrInterp import auPtrPkg::*; #(
  parameter int PTR_MAX  = 782,
  parameter int ACCEPT_N = 3,
  parameter int LOP_N    = 8,
  parameter int AIS_N    = 3,
  parameter int GUARD_N  = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [7:0] dataIn,
  input  logic       h1Strobe,
  input  logic       h2Strobe,
  input  logic       payloadEn,
  input  logic       forceAis,
  output logic [7:0] dataOut,
  output logic [9:0] ptrValue,
  output logic       lopAlarm,
  output logic       aisAlarm,
  output logic       incEvent,
  output logic       decEvent
);
  frameClass_t cls;
  ctrlStrobe_t strb;

  auPtrDatapath #(.PTR_MAX(PTR_MAX)) u_dp (
    .clk(clk), .rstN(rstN), .dataIn(dataIn), .h1Strobe(h1Strobe),
    .h2Strobe(h2Strobe), .payloadEn(payloadEn), .strb(strb),
    .cls(cls), .dataOut(dataOut)
  );

  auPtrControl #(
    .PTR_MAX(PTR_MAX), .ACCEPT_N(ACCEPT_N), .LOP_N(LOP_N),
    .AIS_N(AIS_N), .GUARD_N(GUARD_N)
  ) u_ctl (
    .clk(clk), .rstN(rstN), .cls(cls), .forceAis(forceAis), .strb(strb),
    .ptrValue(ptrValue), .lopAlarm(lopAlarm), .aisAlarm(aisAlarm),
    .incEvent(incEvent), .decEvent(decEvent)
  );
endmodule

// File: rtl/auPtrInterp_chk.sv
module auPtrInterp_chk #(
  parameter int PTR_MAX = 782
) (
  input logic       clk,
  input logic       rstN,
  input logic [7:0] dataIn,
  input logic       h2Strobe,
  input logic       payloadEn,
  input logic       forceAis,
  input logic [7:0] dataOut,
  input logic [9:0] ptrValue,
  input logic       lopAlarm,
  input logic       aisAlarm,
  input logic       incEvent,
  input logic       decEvent
);
  localparam logic [9:0] TOP = 10'(PTR_MAX);

  a_r11_alarm_excl: assert property (@(posedge clk) disable iff (!rstN)
    !(lopAlarm && aisAlarm));

  a_r11_hold: assert property (@(posedge clk) disable iff (!rstN)
    !h2Strobe |=> ($stable(ptrValue) && $stable(lopAlarm) && $stable(aisAlarm)
                   && $stable(incEvent) && $stable(decEvent)));

  a_r10_fill: assert property (@(posedge clk) disable iff (!rstN)
    (payloadEn && (lopAlarm || aisAlarm || forceAis)) |=> dataOut == 8'hFF);

  a_r10_pass: assert property (@(posedge clk) disable iff (!rstN)
    (!payloadEn || !(lopAlarm || aisAlarm || forceAis)) |=> dataOut == $past(dataIn));

  a_r2_range: assert property (@(posedge clk) disable iff (!rstN)
    ptrValue <= TOP);

  a_r4_step: assert property (@(posedge clk) disable iff (!rstN)
    $rose(incEvent) |-> ptrValue == (($past(ptrValue) == TOP) ? 10'd0 : $past(ptrValue) + 10'd1));

  a_r5_step: assert property (@(posedge clk) disable iff (!rstN)
    $rose(decEvent) |-> ptrValue == (($past(ptrValue) == 10'd0) ? TOP : $past(ptrValue) - 10'd1));

  a_r4_r5_excl: assert property (@(posedge clk) disable iff (!rstN)
    !(incEvent && decEvent));
endmodule

bind auPtrInterp auPtrInterp_chk #(.PTR_MAX(PTR_MAX)) u_chk (
  .clk(clk), .rstN(rstN), .dataIn(dataIn), .h2Strobe(h2Strobe),
  .payloadEn(payloadEn), .forceAis(forceAis), .dataOut(dataOut),
  .ptrValue(ptrValue), .lopAlarm(lopAlarm), .aisAlarm(aisAlarm),
  .incEvent(incEvent), .decEvent(decEvent)
);

// File: tb/sim_auPtrInterp.sv
module sim_auPtrInterp;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] dataIn = '0;
  logic h1Strobe = 1'b0, h2Strobe = 1'b0, payloadEn = 1'b0, forceAis = 1'b0;
  logic [7:0] dataOut;
  logic [9:0] ptrValue;
  logic lopAlarm, aisAlarm, incEvent, decEvent;
  int nTests = 0;
  int nFail  = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  auPtrInterp u0 (
    .clk(clk), .rstN(rstN), .dataIn(dataIn), .h1Strobe(h1Strobe),
    .h2Strobe(h2Strobe), .payloadEn(payloadEn), .forceAis(forceAis),
    .dataOut(dataOut), .ptrValue(ptrValue), .lopAlarm(lopAlarm),
    .aisAlarm(aisAlarm), .incEvent(incEvent), .decEvent(decEvent)
  );

  task automatic chk(input string req, input int act, input int exp);
    nTests++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic sendFrame(input logic [7:0] h1, input logic [7:0] h2);
    @(negedge clk); dataIn = h1; h1Strobe = 1'b1;
    @(negedge clk); h1Strobe = 1'b0; h2Strobe = 1'b1; dataIn = h2;
    @(negedge clk); h2Strobe = 1'b0; payloadEn = 1'b1; dataIn = 8'h3C;
    @(negedge clk); payloadEn = 1'b0; dataIn = 8'h00;
  endtask

  task automatic normFrame(input int p);
    logic [9:0] v = 10'(p);
    sendFrame({4'b0110, 2'b00, v[9:8]}, v[7:0]);
  endtask

  task automatic ndfFrame(input logic [3:0] n, input int p);
    logic [9:0] v = 10'(p);
    sendFrame({n, 2'b00, v[9:8]}, v[7:0]);
  endtask

  task automatic t_reset;
    chk("R1 lop after reset", lopAlarm, 1);
    chk("R1 ais after reset", aisAlarm, 0);
    chk("R1 ptr after reset", ptrValue, 0);
    chk("R1 flags after reset", {incEvent, decEvent}, 0);
  endtask

  task automatic t_accept;
    normFrame(100); normFrame(100);
    chk("R2 lop after two frames", lopAlarm, 1);
    chk("R10 fill during lop", dataOut, 8'hFF);
    normFrame(100);
    chk("R2 lop cleared on third", lopAlarm, 0);
    chk("R2 ptr accepted", ptrValue, 100);
    chk("R10 payload passes", dataOut, 8'h3C);
  endtask

  task automatic t_incDec;
    for (int i = 0; i < 3; i++) normFrame(100);
    normFrame(100 ^ 10'h2AA);
    chk("R4 inc ptr", ptrValue, 101);
    chk("R4 incEvent", incEvent, 1);
    normFrame(101 ^ 10'h155);
    chk("R6 guarded ptr unchanged", ptrValue, 101);
    chk("R6 guarded no dec", decEvent, 0);
    chk("R6 inc flag cleared", incEvent, 0);
    for (int i = 0; i < 3; i++) normFrame(101);
    normFrame(101 ^ 10'h155);
    chk("R5 dec ptr", ptrValue, 100);
    chk("R5 decEvent", decEvent, 1);
  endtask

  task automatic t_wrap;
    ndfFrame(4'b1001, 782);
    chk("R3 ndf accept 782", ptrValue, 782);
    for (int i = 0; i < 3; i++) normFrame(782);
    normFrame(782 ^ 10'h2AA);
    chk("R4 inc wraps to 0", ptrValue, 0);
    for (int i = 0; i < 3; i++) normFrame(0);
    normFrame(10'h155);
    chk("R5 dec wraps to 782", ptrValue, 782);
  endtask

  task automatic t_ndf;
    ndfFrame(4'b1001, 500);
    chk("R3 ndf immediate", ptrValue, 500);
    ndfFrame(4'b1011, 600);
    chk("R3 ndf one-bit error", ptrValue, 600);
    chk("R3 no alarm", lopAlarm, 0);
  endtask

  task automatic t_ndfLop;
    normFrame(600);
    for (int i = 0; i < 7; i++) ndfFrame(4'b1001, 300);
    chk("R8 seven ndf no lop", lopAlarm, 0);
    ndfFrame(4'b1001, 300);
    chk("R8 eighth ndf lop", lopAlarm, 1);
  endtask

  task automatic t_ais;
    sendFrame(8'hFF, 8'hFF); sendFrame(8'hFF, 8'hFF);
    chk("R9 two all-ones no ais", aisAlarm, 0);
    sendFrame(8'hFF, 8'hFF);
    chk("R9 ais declared", aisAlarm, 1);
    chk("R9 lop cleared by ais", lopAlarm, 0);
    chk("R10 fill during ais", dataOut, 8'hFF);
    normFrame(200); normFrame(200);
    chk("R9 ais held after two", aisAlarm, 0 + 1);
    normFrame(200);
    chk("R9 ais cleared", aisAlarm, 0);
    chk("R9 ptr after ais exit", ptrValue, 200);
    chk("R10 pass after ais exit", dataOut, 8'h3C);
  endtask

  task automatic t_force;
    forceAis = 1'b1;
    normFrame(200);
    chk("R10 forced fill", dataOut, 8'hFF);
    chk("R10 force raises no alarm", {lopAlarm, aisAlarm}, 0);
    forceAis = 1'b0;
    normFrame(200);
    chk("R10 fill released", dataOut, 8'h3C);
  endtask

  task automatic t_invLop;
    for (int i = 0; i < 7; i++) ndfFrame(4'b0000, 200);
    chk("R7 seven invalid no lop", lopAlarm, 0);
    chk("R7 ptr held", ptrValue, 200);
    ndfFrame(4'b0000, 200);
    chk("R7 eighth invalid lop", lopAlarm, 1);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_accept();
    t_incDec();
    t_wrap();
    t_ndf();
    t_ndfLop();
    t_ais();
    t_force();
    t_invLop();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        nTests++; nFail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule